// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits in one phase of a multiphase buck controller. It turns a single PWM command into two gate enables, one for the high-side switch and one for the low-side switch. Between the two it inserts a non-overlap gap whose length adapts to the power stage. When the high side turns off, the low side waits until the switch node has fallen below its threshold, plus a short fixed delay. When the low side turns off, the high side waits until the low-side gate voltage has fallen below its threshold, plus the same fixed delay. The two threshold crossings come from analog comparators as digital flags that are already synchronous to the fast timing clock.

The switch node may never fall, for example when the inductor current is negative. For that case a watchdog turns the low side on anyway once a fixed time has passed since the high-side turn-off. A global enable turns both gates off. A hold-low input parks the phase with the low side on. All delays are parameters in picoseconds, and the block converts them to clock cycles, rounding up.

Top module: `gate_nonoverlap_seq`

## Requirements
- R1: While rst_n is low, hs_on and ls_on are both 0, and the sequencer starts in an idle state with both gates off.
- R2: hs_on and ls_on are never 1 in the same cycle.
- R3: When gate_en is sampled 0 on a clock edge, both hs_on and ls_on are 0 after that edge. They stay 0 for as long as gate_en stays 0, whatever the other inputs do.
- R4: When the effective command is sampled low while the high side is on, hs_on goes to 0 at that edge. The sequencer then waits for node_low. Once node_low is sampled 1, ls_on rises DLY_CYC edges later. DLY_CYC = ceil(DEAD_PS / CLK_PS), which is 6 with the defaults.
- R5: If node_low is never sampled 1 after the high-side turn-off edge, ls_on rises WD_CYC edges after that edge. WD_CYC = ceil(WDOG_PS / CLK_PS), which is 48 with the defaults. The watchdog takes precedence if node_low is first sampled 1 on the very edge at which it expires.
- R6: When the effective command is sampled high while the low side is on, ls_on goes to 0 at that edge. The sequencer then waits for lgate_low. Once lgate_low is sampled 1, hs_on rises DLY_CYC edges later.
- R7: If the effective command changes while both gates are off (waiting for a flag or counting the delay), the sequence restarts toward the new target from the start of its wait. The gate that was heading on never turns on, and the delay starts over.
- R8: hold_low forces the effective command low. While it is sampled 1, hs_on is 0 after each edge, and the phase settles with the low side on.
- R9: After enabling from idle, a high command enters the wait for lgate_low and a low command enters the wait for node_low. Each then follows R6 or R4/R5 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | Global enable; 0 turns both gates off |
| hold_low | input | 1 | Forces the command low and keeps the high side off |
| pwm_cmd | input | 1 | PWM command, 1 requests the high side |
| node_low | input | 1 | Switch node is below its turn-on threshold |
| lgate_low | input | 1 | Low-side gate voltage is below its threshold |
| hs_on | output | 1 | High-side gate enable (registered) |
| ls_on | output | 1 | Low-side gate enable (registered) |

## Verification
The hardest situations to reach from the ports need exact timing. One is node_low first arriving on the very edge at which the watchdog expires. The others are command reversals that land inside a running delay count rather than during a flag wait. The stimulus handles these by counting clock edges from the high-side turn-off edge. It raises node_low exactly one edge before expiry, and it flips pwm_cmd a few cycles into each delay. A long constrained random run then uses frequent command toggles and sparse, bursty flags, so that restarts interleave with watchdog expiries and enable drops. A cycle model in the bench checks every edge of that run.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_HIGH      = 3'd1,
        PH_WAIT_NODE = 3'd2,
        PH_DLY_LOW   = 3'd3,
        PH_LOW       = 3'd4,
        PH_WAIT_GATE = 3'd5,
        PH_DLY_HIGH  = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   hs;
        logic   ls;
    } seq_s;

    function automatic int cycles_up(input int span_ps, input int clk_ps);
        int c;
        c = (span_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dtg_timer.sv
module dtg_timer #(
    parameter int MAX = 6,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)
            cnt_d = '0;
        else if (cnt_q == W'(MAX))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/gate_nonoverlap_seq.sv
module gate_nonoverlap_seq #(
    parameter int CLK_PS  = 5000,
    parameter int DEAD_PS = 30000,
    parameter int WDOG_PS = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic hold_low,
    input  logic pwm_cmd,
    input  logic node_low,
    input  logic lgate_low,
    output logic hs_on,
    output logic ls_on
);
    import dtg_pkg::*;

    localparam int DLY_CYC = cycles_up(DEAD_PS, CLK_PS);
    localparam int WD_CYC  = cycles_up(WDOG_PS, CLK_PS);
    localparam int DW      = $clog2(DLY_CYC + 1);
    localparam int WW      = $clog2(WD_CYC + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(DLY_CYC - 1);
    localparam logic [WW-1:0] WD_LAST  = WW'(WD_CYC - 1);

    seq_s          st_d, st_q;
    logic          cmd;
    logic          dly_clr, wd_clr;
    logic [DW-1:0] dly_cnt;
    logic [WW-1:0] wd_cnt;

    assign cmd     = pwm_cmd & ~hold_low;
    assign dly_clr = !(st_q.ph == PH_DLY_LOW || st_q.ph == PH_DLY_HIGH);
    assign wd_clr  = (st_q.ph != PH_WAIT_NODE);

    dtg_timer #(.MAX(DLY_CYC)) u_dly (
        .clk(clk), .rst_n(rst_n), .clear(dly_clr), .count(dly_cnt)
    );

    dtg_timer #(.MAX(WD_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .clear(wd_clr), .count(wd_cnt)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE:      st_d.ph = cmd ? PH_WAIT_GATE : PH_WAIT_NODE;
            PH_HIGH:      if (!cmd) st_d.ph = PH_WAIT_NODE;
            PH_WAIT_NODE: begin
                if (cmd)                 st_d.ph = PH_WAIT_GATE;
                else if (wd_cnt == WD_LAST) st_d.ph = PH_LOW;
                else if (node_low)       st_d.ph = PH_DLY_LOW;
            end
            PH_DLY_LOW: begin
                if (cmd)                      st_d.ph = PH_WAIT_GATE;
                else if (dly_cnt == DLY_LAST) st_d.ph = PH_LOW;
            end
            PH_LOW:       if (cmd) st_d.ph = PH_WAIT_GATE;
            PH_WAIT_GATE: begin
                if (!cmd)          st_d.ph = PH_WAIT_NODE;
                else if (lgate_low) st_d.ph = PH_DLY_HIGH;
            end
            PH_DLY_HIGH: begin
                if (!cmd)                     st_d.ph = PH_WAIT_NODE;
                else if (dly_cnt == DLY_LAST) st_d.ph = PH_HIGH;
            end
            default:      st_d.ph = PH_IDLE;
        endcase
        if (!gate_en) st_d.ph = PH_IDLE;
        st_d.hs = (st_d.ph == PH_HIGH);
        st_d.ls = (st_d.ph == PH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, hs: 1'b0, ls: 1'b0};
        else        st_q <= st_d;
    end

    assign hs_on = st_q.hs;
    assign ls_on = st_q.ls;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> !ls_on); // R2
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (!hs_on && !ls_on)); // R3
    AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> ($past(dly_cnt) == DLY_LAST || $past(wd_cnt) == WD_LAST)); // R4
    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_WAIT_NODE && wd_cnt == WD_LAST && gate_en && !cmd) |=> ls_on); // R5
    AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(dly_cnt) == DLY_LAST); // R6
    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DLY_LOW && cmd && gate_en) |=> (st_q.ph == PH_WAIT_GATE && !ls_on)); // R7
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold_low |=> !hs_on); // R8

endmodule

// File: tb/sim_gate_nonoverlap_seq.sv
`timescale 1ns/1ps
module sim_gate_nonoverlap_seq;

    localparam int DLY = 6;
    localparam int WD  = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic gate_en = 1'b0, hold_low = 1'b0, pwm_cmd = 1'b0;
    logic node_low = 1'b0, lgate_low = 1'b0;
    logic hs_on, ls_on;

    int errs = 0, checks = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    gate_nonoverlap_seq u0 (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .hold_low(hold_low),
        .pwm_cmd(pwm_cmd), .node_low(node_low), .lgate_low(lgate_low),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    always #2.5 clk = ~clk;

    // bench model: 0 idle,1 high,2 wait node,3 delay low,4 low,5 wait gate,6 delay high
    int m_ph = 0, m_t = 0;

    function automatic int model_next(input int ph, input int t, input bit en,
                                      input bit c, input bit nl, input bit gl);
        if (!en) return 0;
        case (ph)
            0: return c ? 5 : 2;
            1: return c ? 1 : 2;
            2: return c ? 5 : (t >= WD - 1) ? 4 : nl ? 3 : 2;
            3: return c ? 5 : (t >= DLY - 1) ? 4 : 3;
            4: return c ? 5 : 4;
            5: return !c ? 2 : gl ? 6 : 5;
            6: return !c ? 2 : (t >= DLY - 1) ? 1 : 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_t = 0;
        end else begin
            int nx;
            nx = model_next(m_ph, m_t, gate_en, pwm_cmd & ~hold_low, node_low, lgate_low);
            m_t = (nx == m_ph) ? m_t + 1 : 0;
            m_ph = nx;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(!(hs_on && ls_on), "R2", {hs_on, ls_on}, 0);
            chk(hs_on == (m_ph == 1) && ls_on == (m_ph == 4), cur_req,
                {hs_on, ls_on}, {(m_ph == 1), (m_ph == 4)});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_until(input bit want_hs, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (want_hs ? hs_on : ls_on) break;
        end
    endtask

    int n;
    bit seen;

    initial begin
        step(3);
        cur_req = "R1";
        chk(!hs_on && !ls_on, "R1", {hs_on, ls_on}, 0);
        rst_n = 1'b1;
        step(2);
        chk(!hs_on && !ls_on, "R1", {hs_on, ls_on}, 0);

        // R9: enable from idle with a high command
        cur_req = "R9";
        gate_en = 1'b1; pwm_cmd = 1'b1; lgate_low = 1'b1; node_low = 1'b1;
        count_until(1'b1, 100, n);
        chk(n == 2 + DLY, "R9", n, 2 + DLY);

        // R4: high-side off, node already low
        cur_req = "R4";
        pwm_cmd = 1'b0;
        step(1);
        chk(!hs_on && !ls_on, "R4", {hs_on, ls_on}, 0);
        count_until(1'b0, 100, n);
        chk(n == 1 + DLY, "R4", n, 1 + DLY);

        // R6: low-side off, then gate flag
        cur_req = "R6";
        pwm_cmd = 1'b1;
        count_until(1'b1, 100, n);
        chk(n == 2 + DLY, "R6", n, 2 + DLY);

        // R5: node never falls, watchdog expiry
        cur_req = "R5";
        node_low = 1'b0; pwm_cmd = 1'b0;
        count_until(1'b0, 200, n);
        chk(n == 1 + WD, "R5", n, 1 + WD);

        // R5: node flag first seen on the expiry edge
        pwm_cmd = 1'b1;
        count_until(1'b1, 100, n);
        pwm_cmd = 1'b0;
        step(WD);
        node_low = 1'b1;
        step(1);
        chk(ls_on == 1'b1, "R5", ls_on, 1);

        // R7: reversal while waiting for the gate flag and during the high delay
        cur_req = "R7";
        lgate_low = 1'b0; pwm_cmd = 1'b1;
        step(4);
        chk(!hs_on && !ls_on, "R7", {hs_on, ls_on}, 0);
        pwm_cmd = 1'b0;
        count_until(1'b0, 100, n);
        chk(n == 2 + DLY, "R7", n, 2 + DLY);
        lgate_low = 1'b1; pwm_cmd = 1'b1;
        step(4);
        pwm_cmd = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (hs_on) seen = 1'b1;
        end
        chk(!seen && ls_on, "R7", {seen, ls_on}, 1);

        // R7: reversal during the low delay
        pwm_cmd = 1'b1;
        count_until(1'b1, 100, n);
        pwm_cmd = 1'b0;
        step(3);
        pwm_cmd = 1'b1;
        seen = 1'b0;
        n = 0;
        while (n < 100 && !hs_on) begin
            @(negedge clk);
            n++;
            if (ls_on) seen = 1'b1;
        end
        chk(!seen && n == 2 + DLY, "R7", n, 2 + DLY);

        // R3: disable turns both off at the next edge and holds them off
        cur_req = "R3";
        gate_en = 1'b0;
        step(1);
        chk(!hs_on && !ls_on, "R3", {hs_on, ls_on}, 0);
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            pwm_cmd = i[0];
            if (hs_on || ls_on) seen = 1'b1;
        end
        chk(!seen, "R3", seen, 0);

        // R8: hold-low overrides a high command
        cur_req = "R8";
        gate_en = 1'b1; pwm_cmd = 1'b1;
        count_until(1'b1, 100, n);
        hold_low = 1'b1;
        step(1);
        chk(!hs_on, "R8", hs_on, 0);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (hs_on) seen = 1'b1;
        end
        chk(!seen && ls_on, "R8", {seen, ls_on}, 1);
        hold_low = 1'b0;

        // constrained random run against the model
        cur_req = "R7";
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 99) < 8)  pwm_cmd  = ~pwm_cmd;
            if ($urandom_range(0, 99) < 20) node_low = ($urandom_range(0, 9) < 3);
            if ($urandom_range(0, 99) < 20) lgate_low = ($urandom_range(0, 9) < 4);
            gate_en  = ($urandom_range(0, 199) != 0);
            hold_low = ($urandom_range(0, 99) < 2);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule